// File: doc/BRIEF.md
# Serial Result Readout Port with Cascade

This block is the slave-side serial output stage of a 16-bit sampling converter. A stub conversion engine raises a busy indication during each conversion and presents the parallel result. When busy drops, the block captures that result into a holding register. A host reads the word by pulling chip-select and read-enable low and toggling an external serial clock. The word leaves on a single data pin, most significant bit first. All logic runs in the system clock domain. The serial clock and the cascade input are passed through a synchroniser and edge-detected, so the host clock may be slow or stopped at any point.

Two read modes exist. In read-after mode the host reads once busy is low. After the local 16 bits, the port keeps shifting and passes on bits taken from its cascade input. Several devices can then share one data line by chaining each output into the next device's cascade input. The cascade input is sampled on the falling serial clock edge, and the output moves on the rising edge. The first upstream bit therefore follows the local LSB with no gap. In read-during mode the host reads the previous result while the next conversion is in progress. The cascade input is ignored in this mode. If a read was started but fewer than 16 bits were clocked out when busy falls, a one-cycle read-error pulse is raised.

Top module: `serial_result_port`

## Requirements
- R1: After reset, the data output and the read-error output are low and the holding register is zero, so a read before any conversion returns sixteen 0 bits.
- R2: The holding register loads the parallel result on the cycle busy falls, and a later read returns the most recently completed result.
- R3: The data output is low and no shifting takes place unless chip-select and read-enable are both low; serial clock edges while either is high do not advance the word.
- R4: A read presents the word MSB first. The output bit advances one position on each rising serial clock edge and holds through the falling edge; stream bit i (from 0) is word bit 15-i.
- R5: In read-after mode (mode input 0), stream bits 16 onward are the cascade input values sampled on successive falling edges. The first of them appears on the serial cycle right after the local LSB, so in a two-device chain stream bits 16..31 are the upstream word MSB first.
- R6: In read-during mode (mode input 1), the cascade input is ignored and every stream bit after the sixteenth is 0.
- R7: In read-during mode, a read made while busy is high returns the result captured at the previous busy fall.
- R8: In read-during mode, when busy falls after a read was started during that conversion with fewer than 16 rising edges counted, the read-error output is high for exactly one system clock cycle, in the cycle after the fall is seen.
- R9: No read-error pulse occurs when all 16 bits were clocked out before busy fell, when no read was started during the conversion, or in read-after mode.
- R10: Raising chip-select or read-enable ends the session and clears the bit count; the next session restarts at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Conversion in progress, from the conversion engine |
| cs_ni | input | 1 | Chip-select, active low |
| rd_ni | input | 1 | Read-enable, active low |
| mode_i | input | 1 | 0 read-after conversion, 1 read-during conversion |
| sclk_i | input | 1 | External serial clock, asynchronous |
| sdin_i | input | 1 | Cascade data input, asynchronous |
| result_i | input | 16 | Parallel conversion result |
| sdout_o | output | 1 | Serial data output |
| rd_err_o | output | 1 | One-cycle incomplete-read pulse |

## Verification
The hardest situation to reach is the cascade hand-over. The downstream output must switch from its own LSB to the upstream MSB with no slip. This can only be seen with a second device that is itself shifting in step. The bench therefore instantiates two ports in a chain and drives a constant tail bit into the upstream cascade input. It then reads 40 bits and checks the downstream word, the upstream word and the tail in order. The read-error corner is reached by opening a read-during session and clocking a random number of bits from 0 to 20. The session is closed and busy then falls, so partial reads, complete reads and no reads all occur.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {
    RM_AFTER  = 1'b0,
    RM_DURING = 1'b1
  } read_mode_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[s] <= '0;
        else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
#(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  read_mode_e   mode_i,
  input  logic         load_i,
  input  logic [W-1:0] result_i,
  input  logic         sclk_i,
  input  logic         sdin_i,
  output logic         sdout_o,
  output logic         full_o
);
  logic [W-1:0]  hold_q, shreg_q;
  logic [CW-1:0] cnt_q;
  logic          sclk_q, act_q, cas_q;
  logic          rise, fall, start, shin;

  assign rise  = sclk_i & ~sclk_q;
  assign fall  = ~sclk_i & sclk_q;
  assign start = act_i & ~act_q;
  // cascade bit is forced to 0 in read-during mode
  assign shin  = (mode_i == RM_DURING) ? 1'b0 : cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      act_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      act_q  <= act_i;
      if (load_i) hold_q <= result_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      cas_q   <= 1'b0;
    end else if (!act_i) begin
      cnt_q <= '0;
      cas_q <= 1'b0;
    end else if (start) begin
      shreg_q <= hold_q;
      cnt_q   <= '0;
      cas_q   <= 1'b0;
    end else begin
      if (rise) begin
        shreg_q <= {shreg_q[W-2:0], shin};
        if (cnt_q != CW'(W)) cnt_q <= cnt_q + CW'(1);
      end
      if (fall && mode_i == RM_AFTER) cas_q <= sdin_i;
    end
  end

  assign sdout_o = act_i & shreg_q[W-1];
  assign full_o  = (cnt_q == CW'(W));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W)); // R4
  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> cnt_q == '0); // R10
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> $stable(shreg_q)); // R3
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hold_q)); // R2
  AST_DURING_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && act_q && rise && mode_i == RM_DURING) |=> !shreg_q[0]); // R6
endmodule

// File: rtl/srp_rderr.sv
module srp_rderr
  import srp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  read_mode_e mode_i,
  input  logic       busy_i,
  input  logic       act_i,
  input  logic       full_i,
  output logic       busy_fall_o,
  output logic       err_o
);
  logic busy_q, started_q, done_q, err_q;
  logic busy_rise;

  assign busy_rise   = busy_i & ~busy_q;
  assign busy_fall_o = ~busy_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      started_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      busy_q <= busy_i;
      err_q  <= (mode_i == RM_DURING) & busy_fall_o & started_q & ~done_q;
      if (busy_rise) begin
        started_q <= 1'b0;
        done_q    <= 1'b0;
      end else begin
        if (busy_i && act_i)  started_q <= 1'b1;
        if (busy_i && full_i) done_q    <= 1'b1;
      end
    end
  end

  assign err_o = err_q;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8
  AST_ERR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(mode_i == RM_DURING)); // R9
  AST_DONE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && busy_fall_o) |=> !err_o); // R9
  AST_ERR_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_q); // R8
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import srp_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         busy_i,
  input  logic         cs_ni,
  input  logic         rd_ni,
  input  logic         mode_i,
  input  logic         sclk_i,
  input  logic         sdin_i,
  input  logic [W-1:0] result_i,
  output logic         sdout_o,
  output logic         rd_err_o
);
  logic [1:0] sync_q;
  logic       act, busy_fall, full;
  read_mode_e mode;

  assign act  = ~cs_ni & ~rd_ni;
  assign mode = read_mode_e'(mode_i);

  srp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdin_i}),
    .q_o   (sync_q)
  );

  srp_shifter #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .mode_i  (mode),
    .load_i  (busy_fall),
    .result_i(result_i),
    .sclk_i  (sync_q[1]),
    .sdin_i  (sync_q[0]),
    .sdout_o (sdout_o),
    .full_o  (full)
  );

  srp_rderr u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .busy_i     (busy_i),
    .act_i      (act),
    .full_i     (full),
    .busy_fall_o(busy_fall),
    .err_o      (rd_err_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> !sdout_o); // R3
endmodule

// File: tb/serial_result_port_tb_top.sv
module serial_result_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic busy = 1'b0, cs_n = 1'b1, rd_n = 1'b1, mode = 1'b0, sclk = 1'b1, tail = 1'b0;
  logic [15:0] res_dn = '0, res_up = '0;
  logic sd_dn, sd_up, err_dn, err_up;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_result_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy), .cs_ni(cs_n), .rd_ni(rd_n),
    .mode_i(mode), .sclk_i(sclk), .sdin_i(sd_up), .result_i(res_dn),
    .sdout_o(sd_dn), .rd_err_o(err_dn));

  serial_result_port up_i (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy), .cs_ni(cs_n), .rd_ni(rd_n),
    .mode_i(mode), .sclk_i(sclk), .sdin_i(tail), .result_i(res_up),
    .sdout_o(sd_up), .rd_err_o(err_up));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int i, input logic [15:0] dw,
                                   input logic [15:0] uw, input logic t, input bit chain);
    if (i < 16)       return dw[15-i];
    else if (!chain)  return 1'b0;
    else if (i < 32)  return uw[31-i];
    else              return t;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_s();
    cs_n = 1'b0; rd_n = 1'b0; wait_clk(4);
  endtask

  task automatic close_s();
    cs_n = 1'b1; wait_clk(4); rd_n = 1'b1; wait_clk(2);
  endtask

  task automatic clock_bits(input int n, output logic [63:0] dv);
    dv = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; wait_clk(HALF);
      dv[i] = sd_dn;
      sclk = 1'b1; wait_clk(HALF);
    end
  endtask

  task automatic convert(input logic [15:0] d, input logic [15:0] u);
    busy = 1'b1; wait_clk(3);
    res_dn = d; res_up = u;
    busy = 1'b0; wait_clk(3);
  endtask

  // check n stream bits against the expected pattern
  task automatic check_stream(input logic [63:0] dv, input int n, input logic [15:0] dw,
                              input logic [15:0] uw, input logic t, input bit chain,
                              input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < n; i++)
      if (dv[i] !== exp_bit(i, dw, uw, t, chain)) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, first, -1);
  endtask

  task automatic end_conv(input logic [15:0] d, input logic [15:0] u, input bit exp_err,
                          input string req);
    logic e1, e2;
    res_dn = d; res_up = u;
    busy = 1'b0;
    @(negedge clk); e1 = err_dn;
    @(negedge clk); e2 = err_dn;
    chk(e1 == exp_err && e2 == 1'b0, req, {e1, e2}, {exp_err, 1'b0});
    wait_clk(2);
  endtask

  initial begin
    logic [63:0] dv;
    logic [15:0] dw, uw, pw;
    logic t;
    int n;
    void'($urandom(32'd4242));
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(3);

    // R1: reset state and empty read
    chk(sd_dn == 1'b0 && err_dn == 1'b0, "R1 reset outputs", {sd_dn, err_dn}, 0);
    open_s(); clock_bits(16, dv); close_s();
    check_stream(dv, 16, 16'h0000, 16'h0000, 1'b0, 1'b0, "R1 read after reset");

    // R3: idle output low with clock toggling
    convert(16'hFFFF, 16'h0000);
    cs_n = 1'b1; rd_n = 1'b0; clock_bits(3, dv);
    chk(dv[2:0] == 3'b000, "R3 cs high output low", int'(dv[2:0]), 0);
    rd_n = 1'b1; cs_n = 1'b0; clock_bits(3, dv);
    chk(dv[2:0] == 3'b000, "R3 rd high output low", int'(dv[2:0]), 0);
    cs_n = 1'b1; wait_clk(2);

    // R5 R4 R2: random two-device chain reads
    for (int k = 0; k < 20; k++) begin
      dw = 16'($urandom); uw = 16'($urandom); t = 1'($urandom);
      if (k == 0) begin dw = 16'h8001; uw = 16'h0001; t = 1'b1; end
      if (k == 1) begin dw = 16'h0001; uw = 16'h8000; t = 1'b0; end
      convert(dw, uw);
      tail = t;
      open_s(); clock_bits(40, dv); close_s();
      check_stream(dv, 40, dw, uw, t, 1'b1, "R5 R4 R2 chain stream");
    end

    // R10: aborted session restarts at MSB
    dw = 16'hA5C3; convert(dw, 16'h1234);
    open_s(); clock_bits(5, dv); close_s();
    open_s(); clock_bits(16, dv); close_s();
    check_stream(dv, 16, dw, 16'h1234, 1'b0, 1'b1, "R10 restart at MSB");

    // R3: clock edges with rd high do not advance
    cs_n = 1'b0; rd_n = 1'b1; wait_clk(4);
    clock_bits(5, dv);
    rd_n = 1'b0; wait_clk(4);
    clock_bits(16, dv); close_s();
    check_stream(dv, 16, dw, 16'h1234, 1'b0, 1'b1, "R3 no shift while rd high");

    // R9: partial read across busy fall in read-after mode, no error
    busy = 1'b1; wait_clk(3);
    open_s(); clock_bits(4, dv); close_s();
    end_conv(16'h0F0F, 16'h0, 1'b0, "R9 no error in read-after mode");

    // read-during mode
    mode = 1'b1; tail = 1'b1; wait_clk(2);
    convert(16'h3C96, 16'hFFFF);
    busy = 1'b1; wait_clk(3);
    open_s(); clock_bits(20, dv); close_s();
    check_stream(dv, 20, 16'h3C96, 16'hFFFF, 1'b1, 1'b0, "R7 R6 previous word then zeros");
    end_conv(16'h1111, 16'h2222, 1'b0, "R9 full read no error");

    busy = 1'b1; wait_clk(3);
    open_s(); clock_bits(7, dv); close_s();
    check_stream(dv, 7, 16'h1111, 16'h2222, 1'b1, 1'b0, "R7 partial word");
    end_conv(16'h5555, 16'h0, 1'b1, "R8 partial read error pulse");

    busy = 1'b1; wait_clk(10);
    end_conv(16'h6666, 16'h0, 1'b0, "R9 no read no error");

    // random read-during sessions
    pw = 16'h6666;
    for (int k = 0; k < 24; k++) begin
      n = int'($urandom_range(0, 20));
      if (k == 0) n = 15;
      if (k == 1) n = 16;
      if (k == 2) n = 1;
      busy = 1'b1; wait_clk(3);
      if (n > 0) begin
        open_s(); clock_bits(n, dv); close_s();
        check_stream(dv, n, pw, 16'h0, 1'b1, 1'b0, "R7 R6 random during read");
      end
      dw = 16'($urandom);
      end_conv(dw, 16'h0, (n > 0 && n < 16), "R8 R9 random error outcome");
      pw = dw;
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule